// File: doc/BRIEF.md
# Bus Activity Suspend Controller

This block sits in a low-speed USB bridge next to the packet engine. It watches a one-cycle bus-event strobe from the line logic and keeps a sticky activity flag that firmware can read and clear. It also runs an inactivity timer that raises an idle indication once the bus has been quiet for the suspend threshold, which is 3 ms. Firmware uses the flag and the idle indication to decide when to put the bridge to sleep.

Firmware enters suspend by setting a bit in the configuration register. It leaves suspend either by clearing that bit or through an external wake input. The block also drives the clock for the attached microcontroller. That clock is derived from the core clock, which runs at twice the 6 MHz reference (12 MHz). Two configuration bits select 6, 3, 2 or 1.5 MHz. The output is held low during suspend or when a separate clock-stop bit is set. It only ever emits whole pulses, so it starts again cleanly at a divider boundary.

The register port is a plain parallel interface with one address bit. Writes take effect on the clock edge. Reads are combinational.

Top module: `bus_suspend_ctrl`

## Requirements
- R1: A high `bus_evt_i` sets the activity flag, visible as status bit 5 (address 0) after the next clock edge.
- R2: Writing status with bit 5 = 1 clears the activity flag. A bus event in the same cycle wins over the clear. A status write with bit 5 = 0 leaves the flag unchanged.
- R3: `idle_o` and status bit 0 go high once IDLE_CYCLES consecutive core cycles have passed with no bus event. Any bus event drops them after the next edge and restarts the count.
- R4: Writing the configuration register (address 1) with bit 4 = 1 enters suspend on the next edge, and writing bit 4 = 0 leaves it. `suspend_o`, configuration bit 4 and status bit 1 all show the suspend state.
- R5: `wake_i` high while suspended clears suspend on the next edge, even if a configuration write sets bit 4 in the same cycle. When the block is not suspended, `wake_i` has no effect.
- R6: Configuration bits [1:0] = s give an output clock whose high and low phases each last s+1 core cycles. This means 00 = 6 MHz, 01 = 3 MHz, 10 = 2 MHz and 11 = 1.5 MHz.
- R7: `mcu_clk_o` stays low while suspended or while configuration bit 2 (clock stop) is set. Every high pulse it emits is full width.
- R8: When suspend or clock stop ends, the first output pulse starts at a divider boundary and has the full s+1 high width.
- R9: While reset is held, both registers read 0, and `suspend_o`, `idle_o` and `mcu_clk_o` are low.
- R10: Configuration reads return the written bits 4, 2, 1 and 0. All other bits of both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the 6 MHz reference |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_evt_i | input | 1 | One-cycle strobe for each detected bus activity |
| wake_i | input | 1 | External wake request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 configuration |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| idle_o | output | 1 | Inactivity threshold reached |
| suspend_o | output | 1 | Bridge is in suspend |
| mcu_clk_o | output | 1 | Divided clock for the microcontroller |

## Verification
A stuck or mis-set activity flag shows at status bit 5 on the first read after the edge that should have changed it. A timer that is off by one shifts the rise of `idle_o` by exactly one cycle, and the bench samples that rise at its exact cycle. A wrong divider count or a misplaced gate decision shows as a wrong high or low width within one output period, or as a truncated first pulse after wake.

// File: rtl/bsc_pkg.sv
// Shared definitions for the bus activity suspend controller.
// Assumes an 8-bit register port with a single address bit.
package bsc_pkg;

    localparam int REG_W  = 8;
    localparam int RATE_W = 2;

    // Register select encoding
    typedef enum logic {
        ADDR_STATUS = 1'b0,
        ADDR_CONFIG = 1'b1
    } reg_addr_e;

    // Status register bit positions
    localparam int ST_IDLE_BIT = 0;
    localparam int ST_SUSP_BIT = 1;
    localparam int ST_ACT_BIT  = 5;

    // Configuration register bit positions
    localparam int CF_RATE_LSB = 0;
    localparam int CF_STOP_BIT = 2;
    localparam int CF_SUSP_BIT = 4;

    // Decoded configuration write fields
    typedef struct packed {
        logic              suspend_req;
        logic              clk_stop;
        logic [RATE_W-1:0] rate_sel;
    } cfg_fields_t;

endpackage

// File: rtl/bsc_activity.sv
// Sticky bus-activity flag plus an inactivity timer.
// Assumes bus_evt_i is a synchronous strobe in the core clock domain.
// The timer saturates at IDLE_CYCLES and restarts on every event.
module bsc_activity #(
    parameter int IDLE_CYCLES = 36000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_evt_i,
    input  logic clr_i,
    output logic act_o,
    output logic idle_o
);

    localparam int              CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

    logic [CNT_W-1:0] quiet_cnt;

    // Activity flag: event sets, clear request resets, event wins
    always_ff @(posedge clk) begin
        if (!rst_n)          act_o <= 1'b0;
        else if (bus_evt_i)  act_o <= 1'b1;
        else if (clr_i)      act_o <= 1'b0;
    end

    // Quiet-time counter: restart on event, saturate at limit
    always_ff @(posedge clk) begin
        if (!rst_n)                 quiet_cnt <= '0;
        else if (bus_evt_i)         quiet_cnt <= '0;
        else if (quiet_cnt != LIMIT) quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign idle_o = (quiet_cnt == LIMIT);

endmodule

// File: rtl/bsc_power.sv
// Suspend state and configuration fields.
// Assumes wake_i is synchronous to clk. Wake only acts while suspended,
// and there it takes priority over a concurrent configuration write.
module bsc_power
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  cfg_fields_t       cfg_wr_i,
    input  logic              wake_i,
    output logic              suspend_o,
    output logic              clk_stop_o,
    output logic [RATE_W-1:0] rate_sel_o
);

    // Suspend state: wake exits, otherwise a config write sets or clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                  suspend_o <= 1'b0;
        else if (suspend_o && wake_i) suspend_o <= 1'b0;
        else if (cfg_we_i)           suspend_o <= cfg_wr_i.suspend_req;
    end

    // Clock-stop and rate fields: loaded on a config write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_stop_o <= 1'b0;
            rate_sel_o <= '0;
        end else if (cfg_we_i) begin
            clk_stop_o <= cfg_wr_i.clk_stop;
            rate_sel_o <= cfg_wr_i.rate_sel;
        end
    end

endmodule

// File: rtl/bsc_clkdiv.sv
// Glitch-free divided clock for the microcontroller.
// Each half period lasts sel+1 core cycles. The rate select is taken only
// at the start of a period, and the run gate only at half-period
// boundaries, so every pulse is full width.
module bsc_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             run_i,
    output logic             clk_o,
    output logic [SEL_W-1:0] sel_act_o
);

    logic [SEL_W-1:0] half_cnt;
    logic             phase;
    logic             boundary;

    assign boundary = (half_cnt == sel_act_o);

    // Half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n)        half_cnt <= '0;
        else if (boundary) half_cnt <= '0;
        else               half_cnt <= half_cnt + 1'b1;
    end

    // Free-running phase of the virtual divided clock
    always_ff @(posedge clk) begin
        if (!rst_n)        phase <= 1'b0;
        else if (boundary) phase <= ~phase;
    end

    // Rate select latched when a new period starts
    always_ff @(posedge clk) begin
        if (!rst_n)                  sel_act_o <= '0;
        else if (boundary && !phase) sel_act_o <= sel_i;
    end

    // Gated output: rises only when a period starts, falls only at mid-period
    always_ff @(posedge clk) begin
        if (!rst_n)        clk_o <= 1'b0;
        else if (boundary) clk_o <= !phase && run_i;
    end

endmodule

// File: rtl/bus_suspend_ctrl.sv
// Top level of the bus activity suspend controller.
// Decodes the register port, combines the activity, power and clock
// sub-blocks, and assembles read data. The core clock runs at twice the
// 6 MHz reference, so the default IDLE_CYCLES of 36000 is 3 ms.
module bus_suspend_ctrl
    import bsc_pkg::*;
#(
    parameter int IDLE_CYCLES = 36000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_evt_i,
    input  logic             wake_i,
    input  logic             reg_we_i,
    input  logic             reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             idle_o,
    output logic             suspend_o,
    output logic             mcu_clk_o
);

    logic              status_we;
    logic              cfg_we;
    logic              clr_req;
    logic              act_flag;
    logic              clk_stop;
    logic [RATE_W-1:0] rate_sel;
    logic [RATE_W-1:0] div_sel;
    cfg_fields_t       cfg_wr;
    logic              unused_wbits;

    // Write decode
    assign status_we = reg_we_i && (reg_addr_i == ADDR_STATUS);
    assign cfg_we    = reg_we_i && (reg_addr_i == ADDR_CONFIG);
    assign clr_req   = status_we && reg_wdata_i[ST_ACT_BIT];

    assign cfg_wr.suspend_req = reg_wdata_i[CF_SUSP_BIT];
    assign cfg_wr.clk_stop    = reg_wdata_i[CF_STOP_BIT];
    assign cfg_wr.rate_sel    = reg_wdata_i[CF_RATE_LSB +: RATE_W];
    assign unused_wbits       = ^{reg_wdata_i[7:6], reg_wdata_i[3]};

    bsc_activity #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_evt_i (bus_evt_i),
        .clr_i     (clr_req),
        .act_o     (act_flag),
        .idle_o    (idle_o)
    );

    bsc_power u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we),
        .cfg_wr_i   (cfg_wr),
        .wake_i     (wake_i),
        .suspend_o  (suspend_o),
        .clk_stop_o (clk_stop),
        .rate_sel_o (rate_sel)
    );

    bsc_clkdiv #(
        .SEL_W (RATE_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (rate_sel),
        .run_i     (!suspend_o && !clk_stop),
        .clk_o     (mcu_clk_o),
        .sel_act_o (div_sel)
    );

    // Read data assembly for the selected register
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_STATUS) begin
            reg_rdata_o[ST_ACT_BIT]  = act_flag;
            reg_rdata_o[ST_SUSP_BIT] = suspend_o;
            reg_rdata_o[ST_IDLE_BIT] = idle_o;
        end else begin
            reg_rdata_o[CF_SUSP_BIT]               = suspend_o;
            reg_rdata_o[CF_STOP_BIT]               = clk_stop;
            reg_rdata_o[CF_RATE_LSB +: RATE_W]     = rate_sel;
        end
    end

endmodule

// File: rtl/bsc_checker.sv
// Property checker for bus_suspend_ctrl, attached by bind.
// Observes ports and sub-block outputs, and measures output pulse widths
// with a local counter.
module bsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_evt_i,
    input logic       wake_i,
    input logic       clr_req,
    input logic       act_flag,
    input logic       idle_o,
    input logic       suspend_o,
    input logic       clk_stop,
    input logic       mcu_clk_o,
    input logic [1:0] div_sel
);

    logic [3:0] hi_len;

    // Length of the current high run of the output clock
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_len <= '0;
        else if (mcu_clk_o) hi_len <= hi_len + 1'b1;
        else                hi_len <= '0;
    end

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_evt_i |=> act_flag);  // R1

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_flag && !clr_req) |=> act_flag);  // R2

    AST_EVT_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_evt_i |=> !idle_o);  // R3

    AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_o && wake_i) |=> !suspend_o);  // R5

    AST_RISE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mcu_clk_o) |-> $past(!suspend_o && !clk_stop));  // R7

    AST_FULL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mcu_clk_o) |-> (hi_len == {2'b00, div_sel} + 4'd1));  // R8

endmodule

bind bus_suspend_ctrl bsc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_evt_i (bus_evt_i),
    .wake_i    (wake_i),
    .clr_req   (clr_req),
    .act_flag  (act_flag),
    .idle_o    (idle_o),
    .suspend_o (suspend_o),
    .clk_stop  (clk_stop),
    .mcu_clk_o (mcu_clk_o),
    .div_sel   (div_sel)
);

// File: tb/sim_bus_suspend_ctrl.sv
// Self-checking bench. Time unit is 1 ps, so the 2500 ps half period
// gives a 200 MHz clock. Inputs change 100 ps after a rising edge, and
// outputs are sampled at that same point.
module sim_bus_suspend_ctrl;

    localparam int IDLE = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_evt_i = 1'b0;
    logic       wake_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic       reg_addr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       idle_o;
    logic       suspend_o;
    logic       mcu_clk_o;

    int n_chk = 0;
    int n_bad = 0;

    bus_suspend_ctrl #(.IDLE_CYCLES(IDLE)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_evt_i   (bus_evt_i),
        .wake_i      (wake_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .idle_o      (idle_o),
        .suspend_o   (suspend_o),
        .mcu_clk_o   (mcu_clk_o)
    );

    always #2500 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #100;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_we_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr_i = a;
        #100;
        d = reg_rdata_o;
    endtask

    // Wait for the output to be at the given level, up to a cap
    task automatic wait_lvl(input logic lvl);
        for (int i = 0; i < 40 && mcu_clk_o !== lvl; i++) tick();
    endtask

    // Count consecutive samples at the current level
    task automatic run_len(input logic lvl, output int len);
        len = 0;
        while (mcu_clk_o === lvl && len < 40) begin
            len++;
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int         h, l;

        // R9: state while reset is held
        repeat (3) tick();
        rd(1'b0, d); chk("R9 status", d, 0);
        rd(1'b1, d); chk("R9 config", d, 0);
        chk("R9 suspend", suspend_o, 0);
        chk("R9 idle", idle_o, 0);
        chk("R9 mcu_clk", mcu_clk_o, 0);
        rst_n = 1'b1;
        tick();

        // R10 / R4: every configuration value written and read back
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, 8'(v));
            rd(1'b1, d);
            chk("R10 config readback", d, v & 8'h17);
            chk("R4 suspend_o", suspend_o, (v >> 4) & 1);
            rd(1'b0, d);
            chk("R4 status suspend bit", d[1], (v >> 4) & 1);
            chk("R10 status spare bits", d & 8'hDC, 0);
        end
        wr(1'b1, 8'h00);

        // R1 / R2: starting flag x event x clear x write-with-bit5-zero
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 2; e++)
                for (int c = 0; c < 2; c++)
                    for (int o = 0; o < 2; o++) begin
                        if (s != 0) begin bus_evt_i = 1'b1; tick(); bus_evt_i = 1'b0; end
                        else wr(1'b0, 8'h20);
                        bus_evt_i = (e != 0);
                        if (c != 0 || o != 0) begin
                            reg_we_i = 1'b1; reg_addr_i = 1'b0;
                            reg_wdata_i = (c != 0) ? 8'h20 : 8'hDF;
                        end
                        tick();
                        bus_evt_i = 1'b0; reg_we_i = 1'b0;
                        rd(1'b0, d);
                        chk((c != 0) ? "R2 flag after clear" : "R1 flag",
                            d[5], e | (s & ~c));
                    end

        // R3: idle rises exactly IDLE cycles after the last event
        bus_evt_i = 1'b1; tick(); bus_evt_i = 1'b0;
        for (int n = 1; n <= IDLE + 5; n++) begin
            tick();
            chk("R3 idle_o", idle_o, (n >= IDLE) ? 1 : 0);
            rd(1'b0, d);
            chk("R3 status idle bit", d[0], (n >= IDLE) ? 1 : 0);
        end
        bus_evt_i = 1'b1; tick(); bus_evt_i = 1'b0;
        chk("R3 idle drops on event", idle_o, 0);
        for (int k = 0; k < 4; k++) begin
            repeat (IDLE - 2) tick();
            chk("R3 idle before limit", idle_o, 0);
            bus_evt_i = 1'b1; tick(); bus_evt_i = 1'b0;
        end

        // R6: high and low widths for every rate select
        for (int s = 0; s < 4; s++) begin
            wr(1'b1, 8'(s));
            repeat (20) tick();
            for (int p = 0; p < 2; p++) begin
                wait_lvl(1'b0); wait_lvl(1'b1);
                run_len(1'b1, h); run_len(1'b0, l);
                chk("R6 high width", h, s + 1);
                chk("R6 low width", l, s + 1);
            end
        end

        // R7 / R8 / R5: gate by suspend (m=0) or clock stop (m=1), then resume
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++) begin
                wr(1'b1, 8'(s) | ((m == 0) ? 8'h10 : 8'h04));
                repeat (10) tick();
                h = 0;
                for (int i = 0; i < 16; i++) begin
                    h += mcu_clk_o;
                    tick();
                end
                chk("R7 output held low", h, 0);
                if (m == 0) begin
                    wake_i = 1'b1; tick(); wake_i = 1'b0;
                    chk("R5 wake clears suspend", suspend_o, 0);
                    rd(1'b1, d);
                    chk("R5 config after wake", d, s);
                end else begin
                    wr(1'b1, 8'(s));
                end
                wait_lvl(1'b1);
                run_len(1'b1, h);
                chk("R8 first pulse width", h, s + 1);
            end

        // R5: wake while running has no effect
        wr(1'b1, 8'h02);
        wake_i = 1'b1; tick(); wake_i = 1'b0;
        chk("R5 wake when running", suspend_o, 0);
        rd(1'b1, d);
        chk("R5 config unchanged by wake", d, 2);

        // R5: wake wins over a simultaneous suspend set
        wr(1'b1, 8'h10);
        chk("R4 suspend entered", suspend_o, 1);
        wake_i = 1'b1;
        wr(1'b1, 8'h10);
        wake_i = 1'b0;
        chk("R5 wake beats set", suspend_o, 0);

        // R4: software exit
        wr(1'b1, 8'h10);
        wr(1'b1, 8'h00);
        chk("R4 software exit", suspend_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule